// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the four level-sensitive interrupt pins (A to D) of each device on one PCI bus and steers them onto a sixteen-line legacy interrupt controller input. Each device also supplies its device/function number. The slot number is the device/function number shifted right by three. A pin is first rotated according to its slot onto one of four shared interrupt lines, called PIRQ0 to PIRQ3. Each shared line has a level register. That register follows the OR of all device pins rotated onto the line, with one clock of latency.

Four byte-wide steering registers, one per shared line, choose which legacy line each shared line drives. A value below 16 names a legacy line. Any value of 16 or more leaves the shared line disconnected. Several shared lines may name the same legacy line, and that legacy line then carries the OR of their levels. The steering registers are written and read through a small byte port that is selected by a 2-bit index. The configuration-space decoding in front of that port is outside this block, and so is the interrupt controller behind the outputs.

Top module: `pirq_router`

## Requirements
- R1: A device pin with index p (A=0, B=1, C=2, D=3) belonging to a device whose device/function number is f drives shared line ((p + (f >> 3) − 1) mod 4). The low three bits of f (the function number) have no effect on this mapping.
- R2: A steering register value of 0 to 15 connects its shared line to the legacy line of that number. Any value of 16 to 255 leaves the shared line connected to no legacy line.
- R3: A synchronous active-high reset sets all four steering registers to 0x80 and clears all four shared-line levels, so every legacy output is low in the first cycle after reset.
- R4: Each legacy output is the OR of the levels of every shared line whose steering register holds that line's number.
- R5: A shared-line level equals the OR of the pins rotated onto it, as sampled at the previous rising clock edge. When all pins are low, all levels return to zero one cycle later.
- R6: After a steering register is written, the outputs reflect the new steering in the next cycle, without any change on the pins.
- R7: A legacy line that no steering register selects is driven low.
- R8: Slot 0 wraps around: on a slot-0 device, pin A drives shared line 3 and pin B drives shared line 0.
- R9: When reg_wr_en is high at a rising edge, the full byte reg_wdata is stored in the steering register selected by reg_sel (0 to 3 selects PIRQ0 to PIRQ3). reg_rdata always returns the full byte of the register that reg_sel selects, including values of 16 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_int | input | NUM_DEV*4 | Interrupt pins: bits [4d+3:4d] are pins D..A of device d, with pin A in the lowest bit |
| dev_devfn | input | NUM_DEV*8 | Device/function number of each device: bits [8d+7:8d] belong to device d |
| reg_sel | input | 2 | Steering register index (selects PIRQ0 to PIRQ3) |
| reg_wr_en | input | 1 | Write strobe for the selected steering register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected steering register |
| legacy_irq | output | 16 | Legacy interrupt controller inputs |

## Verification
A wrong shared-line level or a wrong steering byte shows up on legacy_irq within one cycle. The fault is visible as soon as a pin is raised on a slot whose line is steered, or as soon as a register is read back through reg_rdata. A swizzle error makes an interrupt appear on the legacy line of a neighbouring shared line, so the bench gives each shared line its own legacy number before it compares. A stale level, or a level that has not been cleared, shows up as an output that stays high in the cycle after every pin has gone low.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int PINS_PER_DEV = 4;
    localparam int PIRQ_CNT     = 4;
    localparam int LINE_CNT     = 16;
    localparam int DEVFN_W      = 8;
    localparam int BYTE_W       = 8;
    localparam int PIRQ_IDX_W   = $clog2(PIRQ_CNT);
    localparam int LINE_IDX_W   = $clog2(LINE_CNT);
    localparam logic [BYTE_W-1:0] STEER_RST = 8'h80;

    // Decoded view of one steering byte.
    typedef struct packed {
        logic                  active;
        logic [LINE_IDX_W-1:0] line;
    } steer_t;

    // Shared line reached by pin p of a device with device/function number f.
    function automatic logic [PIRQ_IDX_W-1:0] pirq_of(
        input int unsigned        pin,
        input logic [DEVFN_W-1:0] devfn
    );
        int unsigned slot;
        slot = int'(devfn >> 3);
        return PIRQ_IDX_W'((pin + slot + PIRQ_CNT - 1) % PIRQ_CNT);
    endfunction

    // A byte below the line count names a line; larger values disconnect.
    function automatic steer_t decode_steer(input logic [BYTE_W-1:0] raw);
        steer_t s;
        s.active = (int'(raw) < LINE_CNT);
        s.line   = LINE_IDX_W'(int'(raw) % LINE_CNT);
        return s;
    endfunction

endpackage

// File: rtl/pin_swizzle.sv
module pin_swizzle
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic [NUM_DEV*PINS_PER_DEV-1:0] dev_int,
    input  logic [NUM_DEV*DEVFN_W-1:0]      dev_devfn,
    output logic [PIRQ_CNT-1:0]             pirq_req
);
    localparam int SRC_CNT = NUM_DEV * PINS_PER_DEV;

    // One one-hot contribution per device pin.
    logic [SRC_CNT-1:0][PIRQ_CNT-1:0] contrib;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar p = 0; p < PINS_PER_DEV; p++) begin : g_pin
            logic [PIRQ_IDX_W-1:0] tgt;
            assign tgt = pirq_of(p, dev_devfn[d*DEVFN_W +: DEVFN_W]);
            always_comb begin
                contrib[d*PINS_PER_DEV+p] = '0;
                contrib[d*PINS_PER_DEV+p][tgt] = dev_int[d*PINS_PER_DEV+p];
            end
        end
    end

    always_comb begin
        pirq_req = '0;
        for (int s = 0; s < SRC_CNT; s++) begin
            pirq_req = pirq_req | contrib[s];
        end
    end
endmodule

// File: rtl/pirq_level_latch.sv
module pirq_level_latch
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PIRQ_CNT-1:0] pirq_req,
    output logic [PIRQ_CNT-1:0] level_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= pirq_req;
        end
    end
endmodule

// File: rtl/steer_regs.sv
module steer_regs
    import irq_route_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [PIRQ_IDX_W-1:0]             sel,
    input  logic                              wr_en,
    input  logic [BYTE_W-1:0]                 wdata,
    output logic [BYTE_W-1:0]                 rdata,
    output logic [PIRQ_CNT-1:0][BYTE_W-1:0]   raw_q,
    output steer_t [PIRQ_CNT-1:0]             steer
);
    for (genvar i = 0; i < PIRQ_CNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[i] <= STEER_RST;
            end else if (wr_en && (sel == PIRQ_IDX_W'(i))) begin
                raw_q[i] <= wdata;
            end
        end
        assign steer[i] = decode_steer(raw_q[i]);
    end

    assign rdata = raw_q[sel];
endmodule

// File: rtl/line_combine.sv
module line_combine
    import irq_route_pkg::*;
(
    input  logic [PIRQ_CNT-1:0] level,
    input  steer_t [PIRQ_CNT-1:0] steer,
    output logic [LINE_CNT-1:0] lines
);
    for (genvar k = 0; k < LINE_CNT; k++) begin : g_line
        logic [PIRQ_CNT-1:0] hit;
        for (genvar p = 0; p < PIRQ_CNT; p++) begin : g_src
            assign hit[p] = level[p] && steer[p].active &&
                            (steer[p].line == LINE_IDX_W'(k));
        end
        assign lines[k] = |hit;
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_DEV*4-1:0]            dev_int,
    input  logic [NUM_DEV*8-1:0]            dev_devfn,
    input  logic [1:0]                      reg_sel,
    input  logic                            reg_wr_en,
    input  logic [7:0]                      reg_wdata,
    output logic [7:0]                      reg_rdata,
    output logic [15:0]                     legacy_irq
);
    logic [PIRQ_CNT-1:0]             pirq_req;
    logic [PIRQ_CNT-1:0]             level_q;
    logic [PIRQ_CNT-1:0][BYTE_W-1:0] route_bytes;
    steer_t [PIRQ_CNT-1:0]           steer;

    pin_swizzle #(.NUM_DEV(NUM_DEV)) u_swz (
        .dev_int   (dev_int),
        .dev_devfn (dev_devfn),
        .pirq_req  (pirq_req)
    );

    pirq_level_latch u_lvl (
        .clk      (clk),
        .rst      (rst),
        .pirq_req (pirq_req),
        .level_q  (level_q)
    );

    steer_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (reg_sel),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .raw_q (route_bytes),
        .steer (steer)
    );

    line_combine u_comb (
        .level (level_q),
        .steer (steer),
        .lines (legacy_irq)
    );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_DEV*4-1:0]            dev_int,
    input logic [1:0]                      reg_sel,
    input logic                            reg_wr_en,
    input logic [7:0]                      reg_wdata,
    input logic [15:0]                     legacy_irq,
    input logic [PIRQ_CNT-1:0]             level_q,
    input logic [PIRQ_CNT-1:0][BYTE_W-1:0] route_bytes
);
    // R3: first cycle after reset is quiet with default steering
    assert_reset_state_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (legacy_irq == '0 && route_bytes == {PIRQ_CNT{STEER_RST}}));

    // R5: all pins low at the previous edge gives no output
    assert_level_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dev_int) == '0) |-> legacy_irq == '0);

    // R9: a write lands in the selected register
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr_en)) |-> route_bytes[$past(reg_sel)] == $past(reg_wdata));

    for (genvar p = 0; p < PIRQ_CNT; p++) begin : g_p
        // R4: a high, connected shared line forces its legacy line high
        assert_level_reaches_R4: assert property (@(posedge clk) disable iff (rst)
            (level_q[p] && route_bytes[p] < 8'd16) |-> legacy_irq[route_bytes[p][3:0]]);
    end

    for (genvar k = 0; k < LINE_CNT; k++) begin : g_k
        logic sel_any;
        always_comb begin
            sel_any = 1'b0;
            for (int p = 0; p < PIRQ_CNT; p++) begin
                if (route_bytes[p] == 8'(k)) sel_any = 1'b1;
            end
        end
        // R7: an unselected line stays low
        assert_unselected_low_R7: assert property (@(posedge clk) disable iff (rst)
            !sel_any |-> !legacy_irq[k]);
    end
endmodule

bind pirq_router pirq_router_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dev_int     (dev_int),
    .reg_sel     (reg_sel),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .legacy_irq  (legacy_irq),
    .level_q     (level_q),
    .route_bytes (route_bytes)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
    localparam int ND = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [ND*4-1:0] dev_int = '0;
    logic [ND*8-1:0] dev_devfn;
    logic [1:0]      reg_sel = '0;
    logic            reg_wr_en = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [15:0]     legacy_irq;

    always #5 clk = ~clk;

    pirq_router #(.NUM_DEV(ND)) u0 (
        .clk(clk), .rst(rst), .dev_int(dev_int), .dev_devfn(dev_devfn),
        .reg_sel(reg_sel), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .legacy_irq(legacy_irq)
    );

    typedef struct {
        bit          is_rd;
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] route_m [4];
    logic [7:0] devfn_m [ND];

    function automatic logic [15:0] model_irq();
        logic [3:0]  lvl;
        logic [15:0] r;
        lvl = '0;
        r   = '0;
        for (int d = 0; d < ND; d++) begin
            for (int p = 0; p < 4; p++) begin
                if (dev_int[d*4+p]) lvl[(p + (devfn_m[d] >> 3) + 3) % 4] = 1'b1;
            end
        end
        for (int s = 0; s < 4; s++) begin
            if (route_m[s] < 8'd16 && lvl[s]) r[route_m[s][3:0]] = 1'b1;
        end
        return r;
    endfunction

    // monitor: compares at each falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = it.is_rd ? {8'h00, reg_rdata} : legacy_irq;
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
            end
        end
    end

    task automatic edge_then_expect_irq(input string tag);
        logic [15:0] e;
        e = model_irq();
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        q.push_back('{is_rd: 1'b0, val: e, tag: tag});
    endtask

    task automatic set_pin(input int d, input int p, input bit v, input string tag);
        @(negedge clk); #1;
        dev_int[d*4+p] = v;
        edge_then_expect_irq(tag);
    endtask

    task automatic wr(input int idx, input logic [7:0] v, input string tag);
        @(negedge clk); #1;
        reg_sel = 2'(idx); reg_wdata = v; reg_wr_en = 1'b1;
        route_m[idx] = v;
        edge_then_expect_irq(tag);
    endtask

    task automatic rd(input int idx, input string tag);
        @(negedge clk); #1;
        reg_sel = 2'(idx);
        @(posedge clk); #1;
        q.push_back('{is_rd: 1'b1, val: {8'h00, route_m[idx]}, tag: tag});
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        // dev0 slot 0, dev1 slot 1, dev2 slot 2, dev3 slot 3 func 3
        devfn_m[0] = 8'h00; devfn_m[1] = 8'h08; devfn_m[2] = 8'h10; devfn_m[3] = 8'h1B;
        for (int d = 0; d < ND; d++) dev_devfn[d*8 +: 8] = devfn_m[d];
        for (int i = 0; i < 4; i++) route_m[i] = 8'h80;

        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 1'b0;
        edge_then_expect_irq("R3 outputs low after reset");
        for (int i = 0; i < 4; i++) rd(i, "R3 steering byte resets to 0x80");

        set_pin(1, 0, 1'b1, "R2 unrouted line drives nothing");
        wr(0, 8'd5, "R1 slot1 pinA reaches PIRQ0 -> line 5");
        wr(1, 8'd6, "R6 steering PIRQ1 without pins changes nothing");
        set_pin(0, 0, 1'b1, "R8 slot0 pinA pending on unrouted PIRQ3");
        wr(3, 8'd9, "R8 slot0 pinA on PIRQ3 -> line 9");
        set_pin(0, 0, 1'b0, "R5 level drops after pin release");
        set_pin(0, 1, 1'b1, "R8 slot0 pinB reaches PIRQ0");
        set_pin(0, 1, 1'b0, "R5 pinB release");
        set_pin(3, 2, 1'b1, "R1 slot3 pinC -> PIRQ0, function bits ignored");
        set_pin(3, 2, 1'b0, "R1 slot3 pinC release");
        set_pin(2, 3, 1'b1, "R1 slot2 pinD -> PIRQ0");
        set_pin(2, 3, 1'b0, "R1 slot2 pinD release");
        set_pin(2, 0, 1'b1, "R1 slot2 pinA -> PIRQ1 line 6");
        wr(1, 8'd5, "R4 PIRQ0 and PIRQ1 share line 5");
        set_pin(1, 0, 1'b0, "R4 shared line held by PIRQ1");
        set_pin(2, 0, 1'b0, "R4 shared line drops when both low");
        set_pin(1, 0, 1'b1, "R4 PIRQ0 alone raises line 5");
        wr(0, 8'd12, "R6 re-steer PIRQ0 to line 12 at once");
        wr(0, 8'd15, "R2 value 15 routes to top line");
        wr(0, 8'd16, "R7 value 16 disconnects, all lines low");
        wr(0, 8'hA7, "R2 value 0xA7 disconnects");
        rd(0, "R9 readback keeps full byte 0xA7");
        wr(2, 8'd0, "R9 write PIRQ2 to line 0");
        rd(2, "R9 readback PIRQ2");
        rd(1, "R9 other register untouched");
        set_pin(0, 2, 1'b1, "R8 slot0 pinC -> PIRQ1 line 5");
        set_pin(1, 1, 1'b1, "R1 slot1 pinB -> PIRQ1 line 5");
        set_pin(3, 0, 1'b1, "R1 slot3 pinA -> PIRQ2 line 0");
        @(negedge clk); #1; dev_int = '0;
        edge_then_expect_irq("R5 all pins low clears every line");
        @(negedge clk); #1; dev_int = '1; rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); #1; rst = 1'b0;
        for (int i = 0; i < 4; i++) route_m[i] = 8'h80;
        edge_then_expect_irq("R3 reset with pins high leaves lines low");
        @(negedge clk); #1; dev_int = '0;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule